// File: doc/BRIEF.md
# Per-Profile Round, Window and Clamp Output Stage

This block reduces a wide signed filter sum to a narrow output word. On each clock it receives a 32-bit two's complement sum and a 4-bit profile number. It adds a programmable round offset, picks a 16-bit window out of the 32-bit result, and, when clamping is switched on, holds that window between a signed lower bound and a signed upper bound. The result leaves through a registered 16-bit output.

The block holds sixteen profiles. Each profile has a 32-bit round offset, a 5-bit window position and a 32-bit bound pair, and a single write port loads them. The profile number may change on every clock. Each stream in an interleaved sequence of pixel streams can therefore round, scale and clamp with its own settings. One clamp-enable input applies to all profiles, and it travels through the pipeline with the sum.

Top module: `rsl_out_stage`

## Requirements
- R1: After reset the output is 0, and every round offset, window position and bound register of every profile is 0.
- R2: A sum, profile number and clamp enable that are presented before clock edge k are captured together at edge k. The output that belongs to them appears after edge k+1. The output before edge k+1 still shows the previous result.
- R3: Rounding adds the whole 32-bit round offset of the selected profile to the sum, and the addition wraps modulo 2^32. An offset of 0 leaves the sum unchanged.
- R4: A window position n from 0 to 16 passes bits n+15 down to n of the rounded sum. Position 0 gives bits 15:0 and position 16 gives bits 31:16.
- R5: Window positions from 17 to 31 act as position 16.
- R6: With clamping enabled, a window below the lower bound is replaced by the lower bound, and a window above the upper bound is replaced by the upper bound. Both comparisons are signed 16-bit two's complement.
- R7: With clamping disabled, the window passes to the output unchanged, whatever bounds the profile holds.
- R8: A bound register keeps the lower bound in bits 15:0 and the upper bound in bits 31:16.
- R9: The profile number selects the round offset, window position and bound pair that share its number, and a different profile may be used on each consecutive clock.
- R10: While `wr_en` is high, a clock edge writes `wr_data` into entry `wr_idx` of the bank chosen by `wr_kind`. Kind 0 selects the round offsets, kind 1 the window positions (only `wr_data[4:0]` is kept) and kind 2 the bound pairs. Kind 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sum_i | input | 32 | Signed filter sum |
| prof_i | input | 4 | Profile number for this sum |
| lim_en_i | input | 1 | Clamp enable, captured together with the sum |
| wr_en | input | 1 | Profile register write strobe |
| wr_kind | input | 2 | Bank to write: 0 round, 1 window, 2 bounds, 3 none |
| wr_idx | input | 4 | Profile entry to write |
| wr_data | input | 32 | Write data |
| dout_o | output | 16 | Registered output word |

## Verification
The bench builds the block with its default parameters: a 32-bit sum, a 16-bit output, sixteen profiles and a 5-bit window position. With these values the full window range 0 to 16 and the saturated positions 17 to 31 can all be reached. So can the modulo-2^32 wrap of the round adder and the signed bound comparison at 0x8000. The default of sixteen profiles is enough to switch between several profiles on consecutive clocks. Bank contents are observed only at the output, by selecting a profile and predicting what it should produce.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  typedef enum logic [1:0] {
    WK_ROUND  = 2'd0,
    WK_WINDOW = 2'd1,
    WK_BOUNDS = 2'd2,
    WK_NONE   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/rsl_rst_sync.sv
module rsl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rsl_bank.sv
module rsl_bank #(
  parameter int PROF_N = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(PROF_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [PROF_N];
  logic [PROF_N-1:0] entry_we;

  always_comb begin
    for (int i = 0; i < PROF_N; i++) entry_we[i] = we && (widx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PROF_N; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < PROF_N; i++) if (entry_we[i]) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[ridx];

  // R10: a strobed write is visible in the addressed entry after the edge
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/rsl_window.sv
module rsl_window #(
  parameter int SUM_W = 32,
  parameter int OUT_W = 16,
  parameter int SEL_W = 5,
  localparam int MAX_SHIFT = SUM_W - OUT_W,
  localparam int SH_W = $clog2(MAX_SHIFT + 1)
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic [SUM_W-1:0] round_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_W-1:0] win_o
);
  logic [SUM_W-1:0] rounded;
  logic [SH_W-1:0]  shamt;
  logic [OUT_W-1:0] cand [MAX_SHIFT+1];

  always_comb rounded = sum_i + round_i;

  always_comb begin
    if (sel_i > SEL_W'(MAX_SHIFT)) shamt = SH_W'(MAX_SHIFT);
    else                           shamt = SH_W'(sel_i);
  end

  for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_cand
    assign cand[s] = rounded[s+OUT_W-1:s];
  end

  assign win_o = cand[shamt];
endmodule

// File: rtl/rsl_clamp.sv
module rsl_clamp #(
  parameter int OUT_W = 16
) (
  input  logic             en_i,
  input  logic [OUT_W-1:0] win_i,
  input  logic [OUT_W-1:0] lo_i,
  input  logic [OUT_W-1:0] hi_i,
  output logic [OUT_W-1:0] out_o
);
  logic below, above;

  always_comb begin
    below = $signed(win_i) < $signed(lo_i);
    above = $signed(win_i) > $signed(hi_i);
    if (en_i && below)      out_o = lo_i;
    else if (en_i && above) out_o = hi_i;
    else                    out_o = win_i;
  end
endmodule

// File: rtl/rsl_out_stage.sv
module rsl_out_stage #(
  parameter int SUM_W  = 32,
  parameter int OUT_W  = 16,
  parameter int PROF_N = 16,
  parameter int SEL_W  = 5,
  localparam int IDX_W = $clog2(PROF_N),
  localparam int MAX_SHIFT = SUM_W - OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [IDX_W-1:0] prof_i,
  input  logic             lim_en_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SUM_W-1:0] wr_data,
  output logic [OUT_W-1:0] dout_o
);
  import rsl_pkg::*;

  logic rst_sync_n;
  rsl_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Write decode
  logic we_round, we_win, we_bnd;
  always_comb begin
    we_round = wr_en && (wr_kind == WK_ROUND);
    we_win   = wr_en && (wr_kind == WK_WINDOW);
    we_bnd   = wr_en && (wr_kind == WK_BOUNDS);
  end

  // Stage 1: capture sum, profile and clamp enable together
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [IDX_W-1:0] prof_q, prof_d;
  logic             lim_q, lim_d;

  always_comb begin
    sum_d  = sum_i;
    prof_d = prof_i;
    lim_d  = lim_en_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sum_q  <= '0;
      prof_q <= '0;
      lim_q  <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      prof_q <= prof_d;
      lim_q  <= lim_d;
    end
  end

  // Profile banks, read with the captured profile number
  logic [SUM_W-1:0] round_rd, bnd_rd;
  logic [SEL_W-1:0] sel_rd;

  rsl_bank #(.PROF_N(PROF_N), .DATA_W(SUM_W)) u_round (
    .clk(clk), .rst_n(rst_sync_n), .we(we_round), .widx(wr_idx),
    .wdata(wr_data), .ridx(prof_q), .rdata(round_rd));

  rsl_bank #(.PROF_N(PROF_N), .DATA_W(SEL_W)) u_win (
    .clk(clk), .rst_n(rst_sync_n), .we(we_win), .widx(wr_idx),
    .wdata(wr_data[SEL_W-1:0]), .ridx(prof_q), .rdata(sel_rd));

  rsl_bank #(.PROF_N(PROF_N), .DATA_W(SUM_W)) u_bnd (
    .clk(clk), .rst_n(rst_sync_n), .we(we_bnd), .widx(wr_idx),
    .wdata(wr_data), .ridx(prof_q), .rdata(bnd_rd));

  logic [OUT_W-1:0] lim_lo, lim_hi;
  assign lim_lo = bnd_rd[OUT_W-1:0];
  assign lim_hi = bnd_rd[2*OUT_W-1:OUT_W];

  // Stage 2 datapath
  logic [OUT_W-1:0] win, clamped;

  rsl_window #(.SUM_W(SUM_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_window (
    .sum_i(sum_q), .round_i(round_rd), .sel_i(sel_rd), .win_o(win));

  rsl_clamp #(.OUT_W(OUT_W)) u_clamp (
    .en_i(lim_q), .win_i(win), .lo_i(lim_lo), .hi_i(lim_hi), .out_o(clamped));

  logic [OUT_W-1:0] dout_q, dout_d;
  always_comb dout_d = clamped;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dout_q <= '0;
    else             dout_q <= dout_d;
  end

  assign dout_o = dout_q;

  // R6: with clamping on and an ordered bound pair the output lies inside it
  assert_clamp_inside_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lim_q && ($signed(lim_lo) <= $signed(lim_hi))) |=>
      (($signed(dout_o) >= $signed($past(lim_lo))) && ($signed(dout_o) <= $signed($past(lim_hi)))));

  // R7: with clamping off the window reaches the output untouched
  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lim_q |=> dout_o == $past(win));

  // R5: positions at or above the top give the upper half of the rounded sum
  assert_sel_saturate_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_rd >= SEL_W'(MAX_SHIFT)) |-> win == OUT_W'((sum_q + round_rd) >> MAX_SHIFT));

  // R2, R4: zero offset and position 0 put the captured low bits on the output next cycle
  assert_plain_path_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lim_q && round_rd == '0 && sel_rd == '0) |=> dout_o == $past(sum_q[OUT_W-1:0]));
endmodule

// File: tb/tb_rsl_out_stage.sv
module tb_rsl_out_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] sum_i;
  logic [3:0]  prof_i;
  logic        lim_en_i;
  logic        wr_en;
  logic [1:0]  wr_kind;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [15:0] dout_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] sh_round [16];
  logic [4:0]  sh_sel   [16];
  logic [31:0] sh_bnd   [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsl_out_stage dut (
    .clk(clk), .rst_n(rst_n), .sum_i(sum_i), .prof_i(prof_i), .lim_en_i(lim_en_i),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data), .dout_o(dout_o));

  function automatic logic [15:0] model(logic [31:0] s, logic [3:0] p, logic en);
    logic [31:0] r;
    int n;
    logic [15:0] w, lo, hi;
    r  = s + sh_round[p];
    n  = (sh_sel[p] > 5'd16) ? 16 : int'(sh_sel[p]);
    w  = 16'(r >> n);
    lo = sh_bnd[p][15:0];
    hi = sh_bnd[p][31:16];
    if (en && $signed(w) < $signed(lo)) w = lo;
    else if (en && $signed(w) > $signed(hi)) w = hi;
    return w;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] kind, logic [3:0] idx, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      2'd0: sh_round[idx] = data;
      2'd1: sh_sel[idx]   = data[4:0];
      2'd2: sh_bnd[idx]   = data;
      default: ;
    endcase
  endtask

  task automatic apply_check(string tag, logic [31:0] s, logic [3:0] p, logic en);
    @(negedge clk);
    sum_i = s; prof_i = p; lim_en_i = en;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(tag, dout_o, model(s, p, en));
  endtask

  task automatic t_reset;
    check("R1 output after reset", dout_o, 16'h0000);
    apply_check("R1 round/window zero", 32'h1234_5555, 4'd9, 1'b0);
    apply_check("R1 bounds zero", 32'h0000_5555, 4'd9, 1'b1);
    check("R1 bounds zero literal", dout_o, 16'h0000);
  endtask

  task automatic t_latency;
    apply_check("R2 baseline", 32'h0000_1111, 4'd0, 1'b0);
    @(negedge clk);
    sum_i = 32'h0000_2222;
    @(posedge clk);
    @(negedge clk);
    check("R2 old value after one edge", dout_o, 16'h1111);
    @(posedge clk);
    @(negedge clk);
    check("R2 new value after two edges", dout_o, 16'h2222);
  endtask

  task automatic t_round;
    wr(2'd0, 4'd1, 32'h0000_0020);
    apply_check("R3 wrap", 32'hFFFF_FFF0, 4'd1, 1'b0);
    check("R3 wrap literal", dout_o, 16'h0010);
    wr(2'd0, 4'd2, 32'h0000_0080);
    wr(2'd1, 4'd2, 32'd8);
    apply_check("R3 half lsb", 32'h1234_56C0, 4'd2, 1'b0);
    check("R3 half lsb literal", dout_o, 16'h3457);
  endtask

  task automatic t_window;
    wr(2'd1, 4'd3, 32'd16);
    apply_check("R4 pos 16", 32'hABCD_1234, 4'd3, 1'b0);
    check("R4 pos 16 literal", dout_o, 16'hABCD);
    wr(2'd1, 4'd3, 32'd4);
    apply_check("R4 pos 4", 32'hABCD_1234, 4'd3, 1'b0);
    check("R4 pos 4 literal", dout_o, 16'hD123);
  endtask

  task automatic t_sel_over;
    wr(2'd1, 4'd4, 32'd20);
    apply_check("R5 pos 20", 32'hABCD_1234, 4'd4, 1'b0);
    check("R5 pos 20 literal", dout_o, 16'hABCD);
    wr(2'd1, 4'd4, 32'd31);
    apply_check("R5 pos 31", 32'h8001_7FFF, 4'd4, 1'b0);
    check("R5 pos 31 literal", dout_o, 16'h8001);
  endtask

  task automatic t_limit;
    wr(2'd2, 4'd5, {16'h0100, 16'hFF00});
    apply_check("R6 R8 above upper", 32'h0000_7000, 4'd5, 1'b1);
    check("R6 R8 above literal", dout_o, 16'h0100);
    apply_check("R6 R8 below lower signed", 32'h0000_8000, 4'd5, 1'b1);
    check("R6 R8 below literal", dout_o, 16'hFF00);
    apply_check("R6 inside", 32'h0000_0050, 4'd5, 1'b1);
    check("R6 inside literal", dout_o, 16'h0050);
  endtask

  task automatic t_nolimit;
    apply_check("R7 clamp off", 32'h0000_7000, 4'd5, 1'b0);
    check("R7 clamp off literal", dout_o, 16'h7000);
  endtask

  task automatic t_stream;
    logic [31:0] sv [8];
    logic [3:0]  pv [8];
    logic        ev [8];
    logic [15:0] xv [8];
    wr(2'd1, 4'd10, 32'd16);
    wr(2'd0, 4'd11, 32'h0000_0008);
    wr(2'd1, 4'd11, 32'd4);
    wr(2'd2, 4'd12, {16'h00FF, 16'h0000});
    for (int i = 0; i < 8; i++) begin
      pv[i] = 4'd10 + 4'(i % 3);
      sv[i] = 32'h1357_1238 + 32'(i * 32'h0001_0111);
      ev[i] = (i % 2) == 0;
      xv[i] = model(sv[i], pv[i], ev[i]);
    end
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 2) check($sformatf("R9 stream item %0d", j - 2), dout_o, xv[j-2]);
      if (j < 8) begin
        sum_i = sv[j]; prof_i = pv[j]; lim_en_i = ev[j];
      end
    end
  endtask

  task automatic t_bad_kind;
    wr(2'd3, 4'd6, 32'hFFFF_FFFF);
    apply_check("R10 kind 3 no round/window", 32'h0000_4321, 4'd6, 1'b0);
    check("R10 kind 3 round literal", dout_o, 16'h4321);
    apply_check("R10 kind 3 no bounds", 32'h0000_4321, 4'd6, 1'b1);
    check("R10 kind 3 bounds literal", dout_o, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sh_round[i] = '0; sh_sel[i] = '0; sh_bnd[i] = '0;
    end
    rst_n = 1'b0; sum_i = '0; prof_i = '0; lim_en_i = 1'b0;
    wr_en = 1'b0; wr_kind = '0; wr_idx = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_round();
    t_window();
    t_sel_over();
    t_limit();
    t_nolimit();
    t_stream();
    t_bad_kind();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule